// File: doc/BRIEF.md
# SAR Conversion Sequencer with Comparator-Ready Stepping

This block sequences the decisions of a 10-bit successive-approximation converter whose most significant weight is split across several elements, giving a redundant array with 13 switching states. From the fast external clock it derives a frame-rate sample clock (one frame is 32 external cycles) and a gated comparator strobe. The sample clock starts each frame low for a short tracking window. While it is low the switch controls stay cleared. While it is high the comparator is strobed and the sequencer collects decisions.

A decision is not taken on a fixed clock edge. It is taken when the comparator reports that it has resolved, which shows as the XOR of its two complementary outputs going high. Each such event writes the positive comparator output into the next raw bit and into that bit's switch control. A frame that collects all 13 decisions publishes the raw word with a one-cycle done strobe. A frame that falls short leaves the previous word on the output. Turning the raw bits into binary is done elsewhere.

Top module: `sar_ctl`

## Requirements
- R1: A frame is 32 external clock cycles, counted from reset release. `sample_clk_o` is low for the first 4 cycles of each frame (frame counts 0 to 3) and high for counts 4 to 31.
- R2: `cmp_clk_o` equals `clk_i` AND `sample_clk_o`. It is low whenever `clk_i` is low, and it follows `sample_clk_o` while `clk_i` is high.
- R3: `sw_o` is all zero while `sample_clk_o` is low. A comparator ready event seen while `sample_clk_o` is low is ignored.
- R4: `cmp_p_i` and `cmp_n_i` are registered once. The ready level is the XOR of the two registered values. A decision event is a cycle in which the ready level is 1 after being 0 in the previous cycle, while `sample_clk_o` is 1. The event takes effect at the next clock edge. A ready level that stays high yields only one event.
- R5: Decision k (k = 0 for the first event of a frame) writes the registered `cmp_p_i` value into bit 12-k of the working word, so the first decision lands in the MSB. `sw_o` shows the working word, so every switch control bit is set to match its decision.
- R6: Decision events after the 13th in a frame change neither `sw_o` nor `raw_o`.
- R7: At the edge that takes the 13th decision, `raw_o` loads the full 13-bit word. `done_o` is 1 for exactly the following cycle.
- R8: If a frame ends with fewer than 13 decisions, `raw_o` keeps its previous value and `done_o` stays 0. `raw_o` changes only in the cycle in which `done_o` rises.
- R9: At the edge that leaves frame count 31, the decision count and `sw_o` are cleared. This clear has priority over any event at that edge. A 13th decision taken at that same edge is still published.
- R10: Asynchronous active-low `rst_ni` clears the frame counter, the input registers, the decision count, `sw_o`, `raw_o` and `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast external clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_p_i | input | 1 | Comparator positive output |
| cmp_n_i | input | 1 | Comparator negative output |
| sample_clk_o | output | 1 | Frame-rate sample clock, high in the conversion phase |
| cmp_clk_o | output | 1 | Gated comparator strobe |
| sw_o | output | 13 | Switch control per raw bit (working decision word) |
| raw_o | output | 13 | Last complete raw decision word |
| done_o | output | 1 | One-cycle strobe when `raw_o` is updated |

## Verification
The assertions check, on every cycle:
- the 32-cycle period of the sample clock;
- that the switch controls are cleared during tracking;
- that the switch controls only ever set bits within a conversion phase;
- that `done_o` lasts one cycle;
- that `raw_o` is held in any cycle without a done strobe.

Only the bench scenarios can show the rest:
- that decisions land MSB first with the comparator's value;
- that a ready level held high counts once;
- that events taken during tracking or after the 13th decision are dropped;
- that a frame which is too slow or cut short leaves the old word in place.

The bench shows these by driving comparator sequences with different spacings and start points against a behavioural frame model.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
  typedef enum logic {
    PH_TRACK   = 1'b0,
    PH_CONVERT = 1'b1
  } phase_e;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int DIV_W     = 5,
  parameter int TRACK_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sample_clk_o,
  output logic cmp_clk_o,
  output logic frame_last_o
);
  import sar_ctl_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  phase_e           phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign phase        = (cnt_q >= DIV_W'(TRACK_CYC)) ? PH_CONVERT : PH_TRACK;
  assign sample_clk_o = (phase == PH_CONVERT);
  assign frame_last_o = &cnt_q;
  // comparator strobed only in conversion phase
  assign cmp_clk_o    = clk_i & sample_clk_o;
endmodule

// File: rtl/sar_ready_det.sv
module sar_ready_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_p_i,
  input  logic cmp_n_i,
  output logic evt_o,
  output logic bit_o
);
  logic p_q, n_q, rdy_d_q, rdy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q     <= 1'b0;
      n_q     <= 1'b0;
      rdy_d_q <= 1'b0;
    end else begin
      p_q     <= cmp_p_i;
      n_q     <= cmp_n_i;
      rdy_d_q <= rdy;
    end
  end

  // complementary outputs differ only once resolved
  assign rdy   = p_q ^ n_q;
  assign evt_o = rdy & ~rdy_d_q;
  assign bit_o = p_q;
endmodule

// File: rtl/sar_step_seq.sv
module sar_step_seq #(
  parameter int N_RAW = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             bit_i,
  input  logic             convert_i,
  input  logic             frame_last_i,
  output logic [N_RAW-1:0] work_o,
  output logic [N_RAW-1:0] raw_o,
  output logic             done_o
);
  localparam int STEP_W = $clog2(N_RAW + 1);

  logic [STEP_W-1:0] step_q;
  logic [N_RAW-1:0]  work_q, work_nxt, hit;
  logic [N_RAW-1:0]  raw_q;
  logic              done_q, take, last;

  assign take = evt_i & convert_i & (step_q < STEP_W'(N_RAW));
  assign last = take & (step_q == STEP_W'(N_RAW - 1));

  for (genvar i = 0; i < N_RAW; i++) begin : g_bit
    // decision k lands in bit N_RAW-1-k
    assign hit[i]      = take & (step_q == STEP_W'(N_RAW - 1 - i));
    assign work_nxt[i] = hit[i] ? bit_i : work_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           work_q[i] <= 1'b0;
      else if (frame_last_i) work_q[i] <= 1'b0;
      else if (hit[i])       work_q[i] <= bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      raw_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (frame_last_i) step_q <= '0;
      else if (take)    step_q <= step_q + 1'b1;
      if (last) raw_q <= work_nxt;
      done_q <= last;
    end
  end

  assign work_o = work_q;
  assign raw_o  = raw_q;
  assign done_o = done_q;
endmodule

// File: rtl/sar_ctl.sv
module sar_ctl #(
  parameter int N_RAW     = 13,
  parameter int DIV_W     = 5,
  parameter int TRACK_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_p_i,
  input  logic             cmp_n_i,
  output logic             sample_clk_o,
  output logic             cmp_clk_o,
  output logic [N_RAW-1:0] sw_o,
  output logic [N_RAW-1:0] raw_o,
  output logic             done_o
);
  logic frame_last, evt, dec_bit;

  sar_clk_div #(.DIV_W(DIV_W), .TRACK_CYC(TRACK_CYC)) u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sample_clk_o (sample_clk_o),
    .cmp_clk_o    (cmp_clk_o),
    .frame_last_o (frame_last)
  );

  sar_ready_det u_rdy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmp_p_i (cmp_p_i),
    .cmp_n_i (cmp_n_i),
    .evt_o   (evt),
    .bit_o   (dec_bit)
  );

  sar_step_seq #(.N_RAW(N_RAW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt),
    .bit_i        (dec_bit),
    .convert_i    (sample_clk_o),
    .frame_last_i (frame_last),
    .work_o       (sw_o),
    .raw_o        (raw_o),
    .done_o       (done_o)
  );
endmodule

// File: rtl/sar_ctl_chk.sv
module sar_ctl_chk #(
  parameter int N_RAW = 13,
  parameter int DIV_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_clk_o,
  input logic [N_RAW-1:0] sw_o,
  input logic [N_RAW-1:0] raw_o,
  input logic             done_o
);
  localparam int FRAME = 1 << DIV_W;

  logic             smp_d_q, seen_q;
  logic [DIV_W+1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_d_q <= 1'b0;
      seen_q  <= 1'b0;
      cyc_q   <= '0;
    end else begin
      smp_d_q <= sample_clk_o;
      if (sample_clk_o && !smp_d_q) begin
        seen_q <= 1'b1;
        cyc_q  <= 1;
      end else if (cyc_q < (DIV_W+2)'(FRAME + 1)) begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  AST_FRAME_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_clk_o && !smp_d_q && seen_q) |-> (cyc_q == (DIV_W+2)'(FRAME))); // R1

  AST_SW_IDLE_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_clk_o |-> (sw_o == '0)); // R3

  AST_SW_SET_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_clk_o && $past(sample_clk_o)) |-> (($past(sw_o) & ~sw_o) == '0)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_RAW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(raw_o)); // R8
endmodule

bind sar_ctl sar_ctl_chk #(.N_RAW(N_RAW), .DIV_W(DIV_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_clk_o (sample_clk_o),
  .sw_o         (sw_o),
  .raw_o        (raw_o),
  .done_o       (done_o)
);

// File: tb/tb_sar_ctl.sv
module tb_sar_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_p = 1'b0, cmp_n = 1'b0;
  logic        sample_clk, cmp_clk, done;
  logic [12:0] sw, raw;

  int n_cmp = 0, n_bad = 0, cycles = 0;

  sar_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_p_i(cmp_p), .cmp_n_i(cmp_n),
    .sample_clk_o(sample_clk), .cmp_clk_o(cmp_clk),
    .sw_o(sw), .raw_o(raw), .done_o(done)
  );

  always #2 clk = ~clk;

  // behavioural frame model
  int          m_cnt = 0, m_step = 0;
  logic        m_p = 0, m_n = 0, m_rdy_d = 0;
  logic [12:0] m_work = 0, m_raw = 0;
  logic        m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_step = 0; m_p = 0; m_n = 0; m_rdy_d = 0;
      m_work = 0; m_raw = 0; m_done = 0;
    end else begin
      logic rdy, ev, pub;
      rdy = m_p ^ m_n;
      ev  = rdy && !m_rdy_d && (m_cnt >= 4);
      pub = 1'b0;
      if (ev && m_step < 13) begin
        m_work[12-m_step] = m_p;
        if (m_step == 12) begin m_raw = m_work; pub = 1'b1; end
        m_step++;
      end
      if (m_cnt == 31) begin m_step = 0; m_work = 0; end
      m_done  = pub;
      m_rdy_d = rdy;
      m_p = cmp_p; m_n = cmp_n;
      m_cnt = (m_cnt + 1) % 32;
    end
  end

  task automatic chk(input string tag, input logic [12:0] got, input logic [12:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R1 sample_clk", {12'b0, sample_clk}, {12'b0, (m_cnt >= 4)});
      chk("R2 cmp_clk low phase", {12'b0, cmp_clk}, 13'h0);
      chk("R5 sw", sw, m_work);
      chk("R8 raw", raw, m_raw);
      chk("R7 done", {12'b0, done}, {12'b0, m_done});
      if (m_cnt < 4) chk("R3 sw tracking", sw, 13'h0);
      if (m_cnt == 0) chk("R9 sw cleared", sw, 13'h0);
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) chk("R2 cmp_clk high phase", {12'b0, cmp_clk}, {12'b0, (m_cnt >= 4)});
  end

  task automatic wait_cnt(input int c);
    do @(negedge clk); while (m_cnt != c);
  endtask

  // decision k drives seq[14-k]
  task automatic run_frame(input logic [14:0] seq, input int gap, input int nd, input int start);
    wait_cnt(start);
    for (int k = 0; k < nd; k++) begin
      for (int g = 0; g < gap; g++) begin
        cmp_p = 0; cmp_n = 0; @(negedge clk);
      end
      cmp_p = seq[14-k]; cmp_n = ~seq[14-k]; @(negedge clk);
    end
    cmp_p = 0; cmp_n = 0;
    wait_cnt(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset raw", raw, 13'h0);
    chk("R10 reset sw", sw, 13'h0);
    chk("R10 reset done", {12'b0, done}, 13'h0);
    rst_n = 1'b1;

    run_frame({13'h1A5B, 2'b00}, 1, 13, 2);
    chk("R7 published word", raw, 13'h1A5B);
    run_frame({13'h0F0F, 2'b00}, 2, 13, 2);
    chk("R8 too slow holds", raw, 13'h1A5B);
    run_frame({13'h1555, 2'b00}, 1, 8, 2);
    chk("R8 short frame holds", raw, 13'h1A5B);
    run_frame({13'h1FFF, 2'b00}, 1, 13, 1);
    chk("R3 tracking event dropped", raw, 13'h1A5B);
    run_frame({13'h0ABC, 2'b11}, 1, 15, 2);
    chk("R6 extra decisions ignored", raw, 13'h0ABC);
    run_frame({13'h1FFF, 2'b11}, 0, 13, 2);
    chk("R4 held ready counts once", raw, 13'h0ABC);
    run_frame(15'h0, 1, 13, 2);
    chk("R5 all-zero word", raw, 13'h0);
    run_frame({13'h1001, 2'b00}, 1, 13, 2);
    chk("R5 MSB first", raw, 13'h1001);

    wait_cnt(10);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-frame raw", raw, 13'h0);
    chk("R10 mid-frame sample_clk", {12'b0, sample_clk}, 13'h0);
    @(negedge clk);
    rst_n = 1'b1;
    run_frame({13'h0C3A, 2'b00}, 1, 13, 2);
    chk("R7 after reset", raw, 13'h0C3A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #80000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule